// File: doc/BRIEF.md
# Widening Saturating Multiply-Accumulate Lane

This unit is one arithmetic lane of a vector datapath. Each operation multiplies two narrow operands, scales the product down by dropping half the element width of low-order bits (optionally rounding to nearest with ties upward), and then adds the scaled product to a double-width accumulator or subtracts it. The sum is clamped to the range of the double-width result, and a flag reports whether the clamp was applied. A width code chosen at runtime sets the element width to 8, 16 or 32 bits. Two control bits select signed or unsigned arithmetic and accumulate or subtract.

The surrounding datapath decides whether the second operand is a per-element value or a broadcast scalar, and presents it on the same port either way. Operations enter with a valid strobe and leave two clock cycles later, and a new operation can be accepted on every cycle.

Top module: `wsat_mac_lane`

## Requirements
- R1: Width code 2'b00 selects an 8-bit element, 2'b01 selects 16 bits, and 2'b10 or 2'b11 select 32 bits. Only the low element-width bits of each operand are used, and only the low double-width bits of the accumulator. The result bits above double width read zero.
- R2: The full double-width product is shifted right by half the element width before it is accumulated: 4 bits for 8-bit elements, 8 for 16-bit, 16 for 32-bit.
- R3: When round_up is 1, the value 2^(shift−1) is added to the product before the shift. When round_up is 0, nothing is added, so the shift rounds toward minus infinity.
- R4: In signed mode, operands and accumulator are two's-complement numbers and the shift is arithmetic.
- R5: In unsigned mode, operands and accumulator are zero-extended and the shift is logical.
- R6: When do_sub is 0, the scaled product is added to the accumulator. When do_sub is 1, it is subtracted.
- R7: In signed mode, a sum above the double-width maximum gives the maximum, and a sum below the minimum gives the minimum.
- R8: In unsigned mode, a sum above all-ones gives all-ones, and a subtraction that would go below zero gives zero.
- R9: sat_flag is 1 exactly when the current result was clamped. It is rewritten by every operation and is not sticky.
- R10: out_valid rises exactly two cycles after in_valid, and consecutive operations may be issued on back-to-back cycles.
- R11: After synchronous reset, out_valid, acc_out and sat_flag are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| width_code | input | 2 | Element width select |
| is_signed | input | 1 | 1 = signed arithmetic |
| do_sub | input | 1 | 1 = subtract the scaled product |
| round_up | input | 1 | 1 = round to nearest with ties upward before the shift |
| op_a | input | 32 | First narrow operand |
| op_b | input | 32 | Second narrow operand (vector or broadcast scalar) |
| acc_in | input | 64 | Old accumulator value |
| out_valid | output | 1 | Result strobe |
| acc_out | output | 64 | New accumulator value |
| sat_flag | output | 1 | The result was clamped |

## Verification
Any fault in this lane, whether in a width decode, an extension, the rounding bias or a clamp bound, shows up as a wrong acc_out or sat_flag on the cycle that out_valid rises. That is two cycles after the operation entered. A lost or extra pipeline stage shows up as a valid strobe one cycle early or late, or as results that pair with the wrong operation during back-to-back issue. A flag that fails to clear is caught by a clamped operation followed directly by an unclamped one.

// File: rtl/wmac_pkg.sv
package wmac_pkg;
  typedef struct packed {
    logic [1:0] widx;
    logic       sgn;
    logic       sub;
  } wmac_ctrl_t;

  // maps a width code onto a lane index; codes past the last lane use the widest
  function automatic logic [1:0] width_index(input logic [1:0] code, input int unsigned lanes);
    if (int'(code) < int'(lanes) - 1) return code;
    return 2'(lanes - 1);
  endfunction
endpackage

// File: rtl/wmac_scale.sv
module wmac_scale #(
  parameter int EW    = 8,
  parameter int OUT_W = 66
) (
  input  logic [EW-1:0]            a,
  input  logic [EW-1:0]            b,
  input  logic                     sgn,
  input  logic                     rnd,
  output logic signed [OUT_W-1:0]  scaled
);
  localparam int DROP = EW / 2;
  localparam int PW   = 2 * EW + 2;

  logic signed [EW:0]   ax, bx;
  logic signed [PW-1:0] prod, bias, biased;

  always_comb begin
    ax     = {sgn & a[EW-1], a};
    bx     = {sgn & b[EW-1], b};
    prod   = PW'(ax) * PW'(bx);
    bias   = '0;
    if (rnd) bias[DROP-1] = 1'b1;
    biased = prod + bias;
    scaled = OUT_W'(biased >>> DROP);
  end
endmodule

// File: rtl/wmac_satadd.sv
module wmac_satadd #(
  parameter int ACC_W = 64,
  parameter int EW    = 8
) (
  input  logic [ACC_W-1:0]         acc,
  input  logic signed [ACC_W+1:0]  scaled,
  input  logic                     sgn,
  input  logic                     sub,
  output logic [ACC_W-1:0]         res,
  output logic                     sat
);
  localparam int RW = 2 * EW;
  localparam int SW = ACC_W + 3;

  logic signed [SW-1:0] accx, sum, hi, lo, clamp;

  always_comb begin
    if (sgn) accx = SW'($signed(acc[RW-1:0]));
    else     accx = SW'($signed({1'b0, acc[RW-1:0]}));
    if (sub) sum = accx - SW'(scaled);
    else     sum = accx + SW'(scaled);
    hi = '0;
    lo = '0;
    if (sgn) begin
      hi[RW-2:0] = '1;
      lo         = '1;
      lo[RW-2:0] = '0;
    end else begin
      hi[RW-1:0] = '1;
    end
    sat   = 1'b1;
    clamp = sum;
    if (sum > hi)      clamp = hi;
    else if (sum < lo) clamp = lo;
    else               sat   = 1'b0;
    res         = '0;
    res[RW-1:0] = clamp[RW-1:0];
  end
endmodule

// File: rtl/wsat_mac_lane.sv
module wsat_mac_lane
  import wmac_pkg::*;
#(
  parameter int BASE_EW    = 8,
  parameter int NUM_WIDTHS = 3
) (
  input  logic                                        clk,
  input  logic                                        rst,
  input  logic                                        in_valid,
  input  logic [1:0]                                  width_code,
  input  logic                                        is_signed,
  input  logic                                        do_sub,
  input  logic                                        round_up,
  input  logic [(BASE_EW << (NUM_WIDTHS-1))-1:0]      op_a,
  input  logic [(BASE_EW << (NUM_WIDTHS-1))-1:0]      op_b,
  input  logic [2*(BASE_EW << (NUM_WIDTHS-1))-1:0]    acc_in,
  output logic                                        out_valid,
  output logic [2*(BASE_EW << (NUM_WIDTHS-1))-1:0]    acc_out,
  output logic                                        sat_flag
);
  localparam int MAX_EW = BASE_EW << (NUM_WIDTHS - 1);
  localparam int ACC_W  = 2 * MAX_EW;
  localparam int SC_W   = ACC_W + 2;

  logic [1:0]             widx;
  logic signed [SC_W-1:0] sc_all [NUM_WIDTHS];
  logic signed [SC_W-1:0] sc_sel;

  assign widx = width_index(width_code, NUM_WIDTHS);

  for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_scale
    localparam int EWG = BASE_EW << g;
    wmac_scale #(.EW(EWG), .OUT_W(SC_W)) u_scale (
      .a      (op_a[EWG-1:0]),
      .b      (op_b[EWG-1:0]),
      .sgn    (is_signed),
      .rnd    (round_up),
      .scaled (sc_all[g])
    );
  end

  always_comb begin
    sc_sel = '0;
    for (int i = 0; i < NUM_WIDTHS; i++)
      if (widx == 2'(i)) sc_sel = sc_all[i];
  end

  // stage 1: scaled product and operands held
  logic                   s1_valid;
  wmac_ctrl_t             s1_ctrl;
  logic [ACC_W-1:0]       s1_acc;
  logic signed [SC_W-1:0] s1_scaled;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      s1_ctrl   <= '0;
      s1_acc    <= '0;
      s1_scaled <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_ctrl   <= '{widx: widx, sgn: is_signed, sub: do_sub};
        s1_acc    <= acc_in;
        s1_scaled <= sc_sel;
      end
    end
  end

  // stage 2: saturating add per width, then select
  logic [ACC_W-1:0] res_all [NUM_WIDTHS];
  logic             sat_all [NUM_WIDTHS];
  logic [ACC_W-1:0] res_sel;
  logic             sat_sel;

  for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_sat
    wmac_satadd #(.ACC_W(ACC_W), .EW(BASE_EW << g)) u_sat (
      .acc    (s1_acc),
      .scaled (s1_scaled),
      .sgn    (s1_ctrl.sgn),
      .sub    (s1_ctrl.sub),
      .res    (res_all[g]),
      .sat    (sat_all[g])
    );
  end

  always_comb begin
    res_sel = '0;
    sat_sel = 1'b0;
    for (int i = 0; i < NUM_WIDTHS; i++)
      if (s1_ctrl.widx == 2'(i)) begin
        res_sel = res_all[i];
        sat_sel = sat_all[i];
      end
  end

  wmac_ctrl_t o_ctrl;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      acc_out   <= '0;
      sat_flag  <= 1'b0;
      o_ctrl    <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        acc_out  <= res_sel;
        sat_flag <= sat_sel;
        o_ctrl   <= s1_ctrl;
      end
    end
  end

  // R10: a strobe in emerges exactly two edges later
  assert_latency_R10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ##1 out_valid);
  assert_no_phantom_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ##1 !out_valid);

  // R1: narrowest width leaves the upper result bits clear
  assert_upper_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (out_valid && o_ctrl.widx == 2'd0) |-> (acc_out[ACC_W-1:2*BASE_EW] == '0));

  // R8: unsigned subtract can only clamp to zero
  assert_unsigned_floor_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !o_ctrl.sgn && o_ctrl.sub && sat_flag) |-> (acc_out == '0));

  // R7: signed clamp at the widest width lands on an extreme
  assert_signed_clamp_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && o_ctrl.sgn && sat_flag && o_ctrl.widx == 2'(NUM_WIDTHS-1)) |->
      (acc_out == {1'b0, {(ACC_W-1){1'b1}}} || acc_out == {1'b1, {(ACC_W-1){1'b0}}}));
endmodule

// File: tb/wsat_mac_lane_tb_top.sv
module wsat_mac_lane_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [1:0]  width_code;
  logic        is_signed, do_sub, round_up;
  logic [31:0] op_a, op_b;
  logic [63:0] acc_in;
  logic        out_valid;
  logic [63:0] acc_out;
  logic        sat_flag;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  wsat_mac_lane dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .width_code(width_code),
    .is_signed(is_signed), .do_sub(do_sub), .round_up(round_up),
    .op_a(op_a), .op_b(op_b), .acc_in(acc_in),
    .out_valid(out_valid), .acc_out(acc_out), .sat_flag(sat_flag)
  );

  task automatic chk(input string rq, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", rq, got, exp);
    end
  endtask

  function automatic void ref_mac(input logic [1:0] wc, input bit sg, input bit sb, input bit rn,
                                  input logic [31:0] a, input logic [31:0] b, input logic [63:0] acc,
                                  output logic [63:0] r, output bit st);
    int ew, half;
    logic [31:0] am;
    logic [63:0] cm;
    logic signed [131:0] ax, bx, p, ac, s, hi, lo;
    ew   = (wc == 2'd0) ? 8 : (wc == 2'd1) ? 16 : 32;
    half = ew / 2;
    am   = (ew == 32) ? 32'hffff_ffff : (32'd1 << ew) - 32'd1;
    cm   = (ew == 32) ? 64'hffff_ffff_ffff_ffff : (64'd1 << (2*ew)) - 64'd1;
    ax = $signed({100'd0, a & am});
    if (sg && a[ew-1]) ax = ax - (132'sd1 <<< ew);
    bx = $signed({100'd0, b & am});
    if (sg && b[ew-1]) bx = bx - (132'sd1 <<< ew);
    p = ax * bx;
    if (rn) p = p + (132'sd1 <<< (half - 1));
    p = p >>> half;
    ac = $signed({68'd0, acc & cm});
    if (sg && acc[2*ew-1]) ac = ac - (132'sd1 <<< (2*ew));
    s = sb ? ac - p : ac + p;
    if (sg) begin
      hi = (132'sd1 <<< (2*ew - 1)) - 132'sd1;
      lo = -(132'sd1 <<< (2*ew - 1));
    end else begin
      hi = (132'sd1 <<< (2*ew)) - 132'sd1;
      lo = '0;
    end
    st = 1'b0;
    if (s > hi) begin s = hi; st = 1'b1; end
    else if (s < lo) begin s = lo; st = 1'b1; end
    r = 64'(s) & cm;
  endfunction

  task automatic drive(input logic [1:0] wc, input bit sg, input bit sb, input bit rn,
                       input logic [31:0] a, input logic [31:0] b, input logic [63:0] acc);
    width_code = wc; is_signed = sg; do_sub = sb; round_up = rn;
    op_a = a; op_b = b; acc_in = acc; in_valid = 1'b1;
  endtask

  // one isolated operation, checked at its output cycle
  task automatic run_op(input string rq, input logic [1:0] wc, input bit sg, input bit sb, input bit rn,
                        input logic [31:0] a, input logic [31:0] b, input logic [63:0] acc);
    logic [63:0] er;
    bit es;
    ref_mac(wc, sg, sb, rn, a, b, acc, er, es);
    @(negedge clk);
    drive(wc, sg, sb, rn, a, b, acc);
    @(negedge clk);
    in_valid = 1'b0;
    chk({rq, " R10 early"}, 64'(out_valid), 64'd0);
    @(negedge clk);
    chk({rq, " R10 valid"}, 64'(out_valid), 64'd1);
    chk({rq, " value"}, acc_out, er);
    chk({rq, " R9 flag"}, 64'(sat_flag), 64'(es));
  endtask

  task automatic t_reset;
    rst = 1'b1; in_valid = 1'b0; width_code = 2'd0; is_signed = 1'b0; do_sub = 1'b0;
    round_up = 1'b0; op_a = '0; op_b = '0; acc_in = '0;
    repeat (3) @(negedge clk);
    chk("R11 out_valid", 64'(out_valid), 64'd0);
    chk("R11 acc_out", acc_out, 64'd0);
    chk("R11 sat_flag", 64'(sat_flag), 64'd0);
    rst = 1'b0;
  endtask

  task automatic t_widths;
    // upper garbage must be ignored at the narrower widths
    run_op("R1 w8 garbage", 2'd0, 1'b1, 1'b0, 1'b0, 32'hdead_be07, 32'h1234_5609, 64'hffff_ffff_ffff_0010);
    run_op("R1 w16", 2'd1, 1'b1, 1'b0, 1'b0, 32'hffff_1234, 32'h0000_0567, 64'h1111_2222_0000_0100);
    run_op("R1 code3 as 32", 2'd3, 1'b1, 1'b0, 1'b0, 32'h0001_0000, 32'h0001_0000, 64'd5);
    run_op("R2 shift w8", 2'd0, 1'b0, 1'b0, 1'b0, 32'd16, 32'd1, 64'd0);
    run_op("R2 shift w16", 2'd1, 1'b0, 1'b0, 1'b0, 32'd256, 32'd3, 64'd0);
    run_op("R2 shift w32", 2'd2, 1'b0, 1'b0, 1'b0, 32'h0001_0000, 32'd7, 64'd0);
  endtask

  task automatic t_round;
    run_op("R3 truncate", 2'd0, 1'b0, 1'b0, 1'b0, 32'd3, 32'd5, 64'd0);
    run_op("R3 round up", 2'd0, 1'b0, 1'b0, 1'b1, 32'd3, 32'd5, 64'd0);
    run_op("R3 tie up", 2'd0, 1'b0, 1'b0, 1'b1, 32'd8, 32'd1, 64'd0);
    run_op("R3 neg floor", 2'd0, 1'b1, 1'b0, 1'b0, 32'hff, 32'd1, 64'd0);
    run_op("R3 neg round", 2'd1, 1'b1, 1'b0, 1'b1, 32'hff80, 32'd1, 64'd0);
  endtask

  task automatic t_signs;
    run_op("R4 signed mul", 2'd0, 1'b1, 1'b0, 1'b0, 32'h80, 32'h7f, 64'h0000);
    run_op("R5 unsigned mul", 2'd0, 1'b0, 1'b0, 1'b0, 32'h80, 32'h7f, 64'h0000);
    run_op("R4 neg acc", 2'd1, 1'b1, 1'b0, 1'b0, 32'd100, 32'd100, 64'hffff_ff00);
    run_op("R6 subtract", 2'd1, 1'b1, 1'b1, 1'b0, 32'd1000, 32'd1000, 64'd100);
    run_op("R6 zero product", 2'd2, 1'b1, 1'b1, 1'b1, 32'd0, 32'hffff_ffff, 64'h8000_0000_0000_0000);
  endtask

  task automatic t_saturate;
    for (int w = 0; w < 3; w++) begin
      logic [31:0] mn;
      logic [63:0] mx, mnacc, ones;
      mn    = 32'd1 << ((8 << w) - 1);
      mx    = (64'd1 << ((16 << w) - 1)) - 64'd1;
      mnacc = 64'd1 << ((16 << w) - 1);
      ones  = (w == 2) ? 64'hffff_ffff_ffff_ffff : (64'd1 << (16 << w)) - 64'd1;
      run_op("R7 min*min at max", 2'(w), 1'b1, 1'b0, 1'b1, mn, mn, mx);
      run_op("R7 sub at min", 2'(w), 1'b1, 1'b1, 1'b0, mn, mn, mnacc);
      run_op("R8 unsigned ceil", 2'(w), 1'b0, 1'b0, 1'b0, 32'hffff_ffff, 32'hffff_ffff, ones);
      run_op("R8 unsigned floor", 2'(w), 1'b0, 1'b1, 1'b0, 32'hffff_ffff, 32'hffff_ffff, 64'd1);
    end
  endtask

  task automatic t_not_sticky;
    run_op("R9 sat op", 2'd0, 1'b1, 1'b0, 1'b0, 32'h80, 32'h80, 64'h7fff);
    run_op("R9 clears", 2'd0, 1'b1, 1'b0, 1'b0, 32'd2, 32'd2, 64'd0);
  endtask

  task automatic t_stream;
    logic [63:0] er [8];
    bit es [8];
    logic [1:0]  wc [8];
    logic [31:0] a [8], b [8];
    logic [63:0] acc [8];
    bit sg [8], sb [8], rn [8];
    for (int i = 0; i < 8; i++) begin
      wc[i] = 2'($urandom_range(0, 3)); sg[i] = 1'($urandom); sb[i] = 1'($urandom);
      rn[i] = 1'($urandom); a[i] = $urandom; b[i] = $urandom; acc[i] = {$urandom, $urandom};
      ref_mac(wc[i], sg[i], sb[i], rn[i], a[i], b[i], acc[i], er[i], es[i]);
    end
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        chk("R10 stream valid", 64'(out_valid), 64'd1);
        chk("R10 stream value", acc_out, er[i-2]);
        chk("R10 stream flag", 64'(sat_flag), 64'(es[i-2]));
      end
      if (i < 8) drive(wc[i], sg[i], sb[i], rn[i], a[i], b[i], acc[i]);
      else in_valid = 1'b0;
    end
    @(negedge clk);
    chk("R10 drained", 64'(out_valid), 64'd0);
  endtask

  task automatic t_random;
    for (int i = 0; i < 150; i++)
      run_op("R6 random", 2'($urandom_range(0, 3)), 1'($urandom), 1'($urandom), 1'($urandom),
             $urandom, $urandom, {$urandom, $urandom});
  endtask

  initial begin
    t_reset();
    t_widths();
    t_round();
    t_signs();
    t_saturate();
    t_not_sticky();
    t_stream();
    t_random();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule